// File: doc/BRIEF.md
# FM Operator Phase Increment Calculator

This block turns the pitch settings of one FM synthesis channel into the per-cycle phase step of each operator in that channel. A 10-bit frequency number and a 3-bit octave block are gathered from two byte-wide channel registers. The octave scaling is applied to the frequency number. Each operator lane then scales that value by its own 4-bit multiplier code. The resulting increments feed a phase accumulator elsewhere in the voice pipeline.

A channel either drives a pair of operators or, when it is combined into a four-operator group, all four. A frequency update therefore recomputes either the first two lanes or all four. The lanes that were not recomputed read zero. Results are registered. A one-cycle `valid_out` pulse marks each fresh result, one clock after the `valid_in` that requested it. Between requests the outputs hold their last value.

Top module: `phinc_calc`

## Requirements
- R1: The frequency number is `{freq_hi[1:0], freq_lo[7:0]}`, so `freq_lo` supplies bits 7:0 and `freq_hi[1:0]` supplies bits 9:8.
- R2: The octave block is `freq_hi[4:2]`. Bits 7:5 of `freq_hi` have no effect on any output.
- R3: When the block is 0, the frequency number is shifted right by one, dropping the low bit. For block b from 1 to 7, it is shifted left by b-1.
- R4: For a lane whose multiplier code is nonzero, the increment is the shifted value times the code, truncated to its low INC_W bits.
- R5: For a lane whose multiplier code is 0, the increment is the shifted value shifted right by one, which means a factor of one half.
- R6: With `quad_in` high, all four lanes are computed and `lane_en` is 4'b1111. With `quad_in` low, only lanes 0 and 1 are computed, `lane_en` is 4'b0011, and lanes 2 and 3 of `inc_out` read zero. Lane i uses `mult_in[4*i +: 4]` and drives `inc_out[INC_W*i +: INC_W]`.
- R7: `valid_out` is high for exactly the cycle after each cycle in which `valid_in` is high, and low at all other times. Back-to-back requests give back-to-back results.
- R8: While no request is accepted, `inc_out` and `lane_en` keep their last value.
- R9: After reset, `valid_out`, `lane_en` and `inc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Request a recompute this cycle |
| freq_lo | input | 8 | Low byte of the frequency number |
| freq_hi | input | 8 | Bits 1:0 are frequency bits 9:8; bits 4:2 are the block |
| quad_in | input | 1 | Four-operator group: compute all lanes |
| mult_in | input | LANES*MUL_W (16) | Per-lane multiplier codes, lane 0 in the low bits |
| valid_out | output | 1 | One-cycle pulse marking fresh results |
| lane_en | output | LANES (4) | Lanes recomputed by the last request |
| inc_out | output | LANES*INC_W (80) | Per-lane phase increments, lane 0 in the low bits |

## Verification
The bench builds the block with INC_W set to 18 and leaves the other parameters at their defaults. With the default width of 20, the largest possible product is 1023·64·15 = 982080, which never exceeds 20 bits, so the truncation would never be exercised. The narrower 18-bit output makes the wrap at the top of the increment reachable: the maximum frequency number at block 7 with multiplier 15 must come out as 195648. The shifter and multiplier stay at their normal sizes, so every block value and every multiplier code, including the half-rate code 0, is still covered at full range.

// File: rtl/phinc_pkg.sv
package phinc_pkg;

  typedef enum logic {
    GRP_PAIR = 1'b0,
    GRP_QUAD = 1'b1
  } grp_mode_e;

  // Lane i is active when the group is quad, or when i is one of the pair lanes.
  function automatic logic lane_active(input grp_mode_e mode, input int lane, input int pair_lanes);
    return (mode == GRP_QUAD) || (lane < pair_lanes);
  endfunction

endpackage

// File: rtl/phinc_shift.sv
module phinc_shift #(
  parameter int FNUM_W = 10,
  parameter int BLK_W  = 3,
  parameter int SH_W   = FNUM_W + (1 << BLK_W) - 2
) (
  input  logic [FNUM_W-1:0] fnum,
  input  logic [BLK_W-1:0]  blk,
  output logic [SH_W-1:0]   sh_val
);

  // Octave scaling: block 0 halves, block b scales by 2^(b-1).
  function automatic logic [SH_W-1:0] octave_scale(input logic [FNUM_W-1:0] f,
                                                   input logic [BLK_W-1:0] b);
    logic [SH_W-1:0] wide;
    wide = SH_W'(f);
    if (b == '0) return wide >> 1;
    return wide << (b - BLK_W'(1));
  endfunction

  assign sh_val = octave_scale(fnum, blk);

endmodule

// File: rtl/phinc_lane.sv
module phinc_lane #(
  parameter int SH_W  = 16,
  parameter int MUL_W = 4,
  parameter int INC_W = 20
) (
  input  logic [SH_W-1:0]  sh_val,
  input  logic [MUL_W-1:0] mult,
  input  logic             active,
  output logic [INC_W-1:0] inc
);

  localparam int PROD_W = SH_W + MUL_W;

  // Code 0 means one half; any other code is an integer factor, wrapped to INC_W bits.
  function automatic logic [INC_W-1:0] apply_mult(input logic [SH_W-1:0] s,
                                                  input logic [MUL_W-1:0] m);
    logic [PROD_W-1:0] prod;
    if (m == '0) begin
      prod = PROD_W'(s >> 1);
    end else begin
      prod = PROD_W'(s) * PROD_W'(m);
    end
    return INC_W'(prod);
  endfunction

  assign inc = active ? apply_mult(sh_val, mult) : '0;

endmodule

// File: rtl/phinc_calc.sv
module phinc_calc
  import phinc_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int LO_W       = 8,
  parameter int FNUM_W     = 10,
  parameter int BLK_W      = 3,
  parameter int MUL_W      = 4,
  parameter int INC_W      = 20,
  parameter int LANES      = 4,
  parameter int PAIR_LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_in,
  input  logic [LO_W-1:0]        freq_lo,
  input  logic [REG_W-1:0]       freq_hi,
  input  logic                   quad_in,
  input  logic [LANES*MUL_W-1:0] mult_in,
  output logic                   valid_out,
  output logic [LANES-1:0]       lane_en,
  output logic [LANES*INC_W-1:0] inc_out
);

  localparam int HI_W    = FNUM_W - LO_W;
  localparam int BLK_LSB = HI_W;
  localparam int SH_W    = FNUM_W + (1 << BLK_W) - 2;

  // Decoded fields, brought out as named wires.
  logic [FNUM_W-1:0]      fnum_w;
  logic [BLK_W-1:0]       blk_w;
  logic [SH_W-1:0]        sh_w;
  grp_mode_e              mode_w;
  logic [LANES-1:0]       en_w;
  logic [LANES*INC_W-1:0] inc_w;
  logic                   load_w;

  assign fnum_w = {freq_hi[HI_W-1:0], freq_lo};
  assign blk_w  = freq_hi[BLK_LSB +: BLK_W];
  assign mode_w = quad_in ? GRP_QUAD : GRP_PAIR;
  assign load_w = valid_in;

  phinc_shift #(
    .FNUM_W(FNUM_W),
    .BLK_W (BLK_W),
    .SH_W  (SH_W)
  ) u_shift (
    .fnum  (fnum_w),
    .blk   (blk_w),
    .sh_val(sh_w)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign en_w[i] = lane_active(mode_w, i, PAIR_LANES);

    phinc_lane #(
      .SH_W (SH_W),
      .MUL_W(MUL_W),
      .INC_W(INC_W)
    ) u_lane (
      .sh_val(sh_w),
      .mult  (mult_in[i*MUL_W +: MUL_W]),
      .active(en_w[i]),
      .inc   (inc_w[i*INC_W +: INC_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      lane_en   <= '0;
      inc_out   <= '0;
    end else begin
      valid_out <= load_w;
      if (load_w) begin
        lane_en <= en_w;
        inc_out <= inc_w;
      end
    end
  end

endmodule

// File: rtl/phinc_calc_chk.sv
module phinc_calc_chk #(
  parameter int INC_W      = 20,
  parameter int LANES      = 4,
  parameter int PAIR_LANES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_in,
  input logic                   quad_in,
  input logic                   valid_out,
  input logic [LANES-1:0]       lane_en,
  input logic [LANES*INC_W-1:0] inc_out
);

  localparam logic [LANES-1:0] PAIR_MASK = LANES'((1 << PAIR_LANES) - 1);

  a_r7_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);

  a_r6_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> (lane_en == ($past(quad_in) ? {LANES{1'b1}} : PAIR_MASK)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(inc_out) && $stable(lane_en)));

  for (genvar i = 0; i < LANES; i++) begin : g_idle
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && !lane_en[i]) |-> (inc_out[i*INC_W +: INC_W] == '0));
  end

endmodule

bind phinc_calc phinc_calc_chk #(
  .INC_W     (INC_W),
  .LANES     (LANES),
  .PAIR_LANES(PAIR_LANES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_in (valid_in),
  .quad_in  (quad_in),
  .valid_out(valid_out),
  .lane_en  (lane_en),
  .inc_out  (inc_out)
);

// File: tb/phinc_calc_tb.sv
module phinc_calc_tb;

  localparam int IW = 18;
  localparam int NL = 4;
  localparam int MW = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_in = 1'b0;
  logic [7:0]        freq_lo = '0;
  logic [7:0]        freq_hi = '0;
  logic              quad_in = 1'b0;
  logic [NL*MW-1:0]  mult_in = '0;
  logic              valid_out;
  logic [NL-1:0]     lane_en;
  logic [NL*IW-1:0]  inc_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [NL*IW-1:0] exp_inc_q[$];
  logic [NL-1:0]    exp_en_q[$];
  string            tag_q[$];
  logic [NL*IW-1:0] last_inc;
  logic [NL-1:0]    last_en;

  always #10 clk = ~clk;

  phinc_calc #(.INC_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .freq_lo(freq_lo),
    .freq_hi(freq_hi), .quad_in(quad_in), .mult_in(mult_in),
    .valid_out(valid_out), .lane_en(lane_en), .inc_out(inc_out)
  );

  // Reference model written from the requirements in integer arithmetic.
  function automatic longint lane_ref(input int lo, input int hi, input int m);
    longint fn, base, v;
    int b;
    fn = longint'(lo) + 256 * longint'(hi % 4);   // R1
    b  = (hi / 4) % 8;                             // R2
    base = (b == 0) ? fn / 2 : fn * (longint'(1) << (b - 1)); // R3
    if (m == 0) v = base / 2;                      // R5
    else v = (base * m) % (longint'(1) << IW);     // R4
    return v;
  endfunction

  task automatic check(input string tag, input logic [NL*IW-1:0] act, input logic [NL*IW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] lo, input logic [7:0] hi, input logic q,
                      input logic [NL*MW-1:0] m, input string tag);
    logic [NL*IW-1:0] e;
    logic [NL-1:0] en;
    @(negedge clk);
    freq_lo = lo; freq_hi = hi; quad_in = q; mult_in = m; valid_in = 1'b1;
    e = '0;
    for (int i = 0; i < NL; i++) begin
      en[i] = q || (i < 2);                        // R6
      if (en[i]) e[i*IW +: IW] = IW'(lane_ref(int'(lo), int'(hi), int'(m[i*MW +: MW])));
    end
    exp_inc_q.push_back(e);
    exp_en_q.push_back(en);
    tag_q.push_back(tag);
    last_inc = e;
    last_en = en;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      freq_lo = 8'h5A; freq_hi = 8'hFF; quad_in = 1'b1; mult_in = 16'hFFFF;
    end
  endtask

  // Monitor: pops one expected item per result pulse.
  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      if (exp_inc_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected valid_out actual=1 expected=0");
      end else begin
        string t;
        logic [NL*IW-1:0] ei;
        logic [NL-1:0] ee;
        t = tag_q.pop_front();
        ei = exp_inc_q.pop_front();
        ee = exp_en_q.pop_front();
        check(t, inc_out, ei);
        check({t, " R6 lane_en"}, NL*IW'(lane_en), NL*IW'(ee));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 valid_out", NL*IW'(valid_out), '0);
    check("R9 lane_en", NL*IW'(lane_en), '0);
    check("R9 inc_out", inc_out, '0);
    rst_n = 1'b1;
    idle(2);

    send(8'h44, 8'h01, 1'b0, 16'h0021, "R1 fnum assembly");
    send(8'hFF, 8'h03, 1'b1, 16'h0000, "R3 R5 block0 mult0 quarter");
    send(8'h23, 8'h06, 1'b1, 16'h1234, "R3 block1 unshifted");
    send(8'hFF, 8'h1F, 1'b1, 16'hF0F1, "R4 wrap at INC_W");
    send(8'h80, 8'h0E, 1'b0, 16'h9876, "R6 pair lanes only");
    send(8'h10, 8'h11, 1'b1, 16'h0F05, "R3 block4 mixed");
    idle(3);
    // R8: held after requests stop, inputs toggled meanwhile
    check("R8 hold inc_out", inc_out, last_inc);
    check("R8 hold lane_en", NL*IW'(lane_en), NL*IW'(last_en));
    check("R7 valid_out low when idle", NL*IW'(valid_out), '0);

    // R2: upper bits of freq_hi ignored; same fields with bits 7:5 set
    send(8'h3C, 8'h0A, 1'b1, 16'h3210, "R2 baseline");
    idle(1);
    send(8'h3C, 8'hEA, 1'b1, 16'h3210, "R2 high bits ignored");
    idle(2);

    for (int b = 0; b < 8; b++) begin
      send(8'hA5, 8'((b << 2) | 2), 1'b1, 16'h1F80, "R3 R4 R5 block sweep");
    end
    idle(1);
    for (int m = 0; m < 16; m += 4) begin
      send(8'h77, 8'h0D, (m % 8) == 0, 16'((m + 3) << 12 | (m + 2) << 8 | (m + 1) << 4 | m),
           "R4 R5 R6 multiplier sweep");
    end
    idle(3);
    check("R7 all results delivered", NL*IW'(exp_inc_q.size()), '0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule